// File: doc/BRIEF.md
# Two-Tier Priority Round-Robin Receive DMA Arbiter

This block decides which receive FIFO is served by a shared DMA engine. There is one FIFO for each bus instance. A FIFO takes part in arbitration only when two conditions hold together: its request queue is not empty, and the FIFO holds the data that the head request needs. The FIFOs are split into two speed groups. Group A is the first `NUM_A` requesters and group B is the rest. Each requester also has one priority bit.

Within a group, eligible high-priority requesters are served in round-robin order. Low-priority requesters in that group are considered only when no high-priority requester there is eligible. Each class of each group keeps its own round-robin pointer. When both groups have work, a weighting rule picks between them: group A may win up to `ratio_a_i` packets in a row, and group B up to `ratio_b_i`. A group with no eligible requester is passed over at once.

A grant covers one whole packet. The DMA engine pulses `done_i` for each request it completes and raises `last_i` with the request that ends the packet. A scatter-gather packet is made of several requests, and the grant stays locked on one requester until its last request completes. A new decision is made in the same cycle, so two grants can follow each other with no gap.

Top module: `rx_dma_arb`

## Requirements
- R1: After a synchronous reset, `gnt_o` is all zeros, and `gnt_valid_o` and `gnt_grp_o` are 0. All round-robin pointers restart at index 0. Group A is preferred for the first contested decision.
- R2: A requester is eligible only when both its `q_nempty_i` bit and its `fifo_rdy_i` bit are 1. If no requester is eligible at an arbitration point, the grant becomes all zeros and `gnt_valid_o` goes to 0.
- R3: Within the chosen group, an eligible requester whose `prio_i` bit is 1 (high) always wins over one whose bit is 0 (low).
- R4: Eligible high-priority requesters of a group are served round-robin. After a win, that class's pointer moves to the index just past the winner, wrapping to 0. The next search starts at the pointer and moves upward.
- R5: Low-priority requesters of a group are served round-robin, with their own pointer, only when that group has no eligible high-priority requester.
- R6: An arbitration point is any cycle in which `gnt_valid_o` is 0, or in which `done_i` and `last_i` are both 1. A `done_i` pulse with `last_i` = 0 (scatter-gather continuation) leaves the grant unchanged, even if eligibility changes. When both are 1, the next grant is registered at that same clock edge.
- R7: When both groups are eligible, the group that won the last packet keeps winning until it has `ratio_a_i` (group A) or `ratio_b_i` (group B) packets in a row. The other group then wins. Its count starts again at 1.
- R8: A group with no eligible requester is skipped at once, whatever its remaining budget. No unused budget is carried over.
- R9: `gnt_o` is one-hot whenever `gnt_valid_o` is 1. `gnt_grp_o` is 0 for a group A winner (index below `NUM_A`) and 1 for a group B winner.
- R10: A ratio value of 0 is treated as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| q_nempty_i | input | NUM_REQ | Request queue holds at least one DMA request, one bit per FIFO |
| fifo_rdy_i | input | NUM_REQ | FIFO holds the data that the queued request needs |
| prio_i | input | NUM_REQ | Priority bit for each FIFO (1 = high, 0 = low) |
| ratio_a_i | input | RATIO_W | Maximum consecutive packets for group A (0 is treated as 1) |
| ratio_b_i | input | RATIO_W | Maximum consecutive packets for group B (0 is treated as 1) |
| done_i | input | 1 | The DMA engine has completed one request for the current grant |
| last_i | input | 1 | The completed request ends the packet |
| gnt_o | output | NUM_REQ | Registered one-hot grant |
| gnt_valid_o | output | 1 | A grant is held |
| gnt_grp_o | output | 1 | Group of the current grant (0 = A, 1 = B) |

## Verification
Every result is due one clock edge after the arbitration point that produces it. The inputs are driven at a falling edge, the decision is registered at the next rising edge, and the bench samples `gnt_o`, `gnt_valid_o` and `gnt_grp_o` at the falling edge that follows. A release with `done_i` and `last_i` both high produces the next grant at that same rising edge, so the bench expects the new winner one half-cycle later. During a scatter-gather continuation the bench re-samples after every `done_i` pulse and checks that the grant has not changed.

// File: rtl/rx_dma_arb_pkg.sv
`timescale 1ns/1ps
package rx_dma_arb_pkg;
  // Class slots: index = {group, low}
  localparam int NUM_CLS  = 4;
  localparam int CLS_A_HI = 0;
  localparam int CLS_A_LO = 1;
  localparam int CLS_B_HI = 2;
  localparam int CLS_B_LO = 3;

  typedef enum logic {GRP_A = 1'b0, GRP_B = 1'b1} grp_e;
endpackage

// File: rtl/rr_pick.sv
`timescale 1ns/1ps
module rr_pick #(
  parameter int W  = 3,
  parameter int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  req_i,
  input  logic [IW-1:0] ptr_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  // Search upward from ptr_i, wrapping; the lowest offset wins.
  always_comb begin
    int j;
    any_o = 1'b0;
    idx_o = '0;
    for (int k = W - 1; k >= 0; k--) begin
      j = (int'(ptr_i) + k) % W;
      if (req_i[j]) begin
        any_o = 1'b1;
        idx_o = IW'(j);
      end
    end
  end
endmodule

// File: rtl/grp_weight.sv
`timescale 1ns/1ps
module grp_weight #(
  parameter int RATIO_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               any_a_i,
  input  logic               any_b_i,
  input  logic [RATIO_W-1:0] ratio_a_i,
  input  logic [RATIO_W-1:0] ratio_b_i,
  input  logic               adv_i,
  output logic               sel_valid_o,
  output logic               sel_b_o
);
  localparam logic [RATIO_W-1:0] RUN_MAX = '1;

  logic               last_b_q;
  logic [RATIO_W-1:0] run_q;
  logic [RATIO_W-1:0] lim_a, lim_b;

  assign lim_a = (ratio_a_i == '0) ? RATIO_W'(1) : ratio_a_i;
  assign lim_b = (ratio_b_i == '0) ? RATIO_W'(1) : ratio_b_i;
  assign sel_valid_o = any_a_i | any_b_i;

  always_comb begin
    if (any_a_i && any_b_i) begin
      if (last_b_q) sel_b_o = (run_q < lim_b);
      else          sel_b_o = !(run_q < lim_a);
    end else begin
      sel_b_o = any_b_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_b_q <= 1'b0;
      run_q    <= '0;
    end else if (adv_i && sel_valid_o) begin
      last_b_q <= sel_b_o;
      if (sel_b_o == last_b_q) run_q <= (run_q == RUN_MAX) ? run_q : run_q + 1'b1;
      else                     run_q <= RATIO_W'(1);
    end
  end

  // R7
  run_bound_chk: assert property (@(posedge clk) disable iff (rst)
    adv_i && sel_valid_o && (sel_b_o != last_b_q) |=> (run_q == RATIO_W'(1)));
endmodule

// File: rtl/rx_dma_arb.sv
`timescale 1ns/1ps
module rx_dma_arb
  import rx_dma_arb_pkg::*;
#(
  parameter int NUM_REQ = 3,
  parameter int NUM_A   = 1,
  parameter int RATIO_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_REQ-1:0] q_nempty_i,
  input  logic [NUM_REQ-1:0] fifo_rdy_i,
  input  logic [NUM_REQ-1:0] prio_i,
  input  logic [RATIO_W-1:0] ratio_a_i,
  input  logic [RATIO_W-1:0] ratio_b_i,
  input  logic               done_i,
  input  logic               last_i,
  output logic [NUM_REQ-1:0] gnt_o,
  output logic               gnt_valid_o,
  output logic               gnt_grp_o
);
  localparam int IW = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1;
  localparam logic [NUM_REQ-1:0] MASK_A = NUM_REQ'((1 << NUM_A) - 1);
  localparam logic [NUM_REQ-1:0] MASK_B = ~MASK_A;

  logic [NUM_REQ-1:0]  elig;
  logic [NUM_REQ-1:0]  cls_req [NUM_CLS];
  logic [NUM_CLS-1:0]  cls_any;
  logic [IW-1:0]       cls_idx [NUM_CLS];
  logic [IW-1:0]       ptr_q   [NUM_CLS];
  logic                any_a, any_b, fire, sel_valid, sel_b;
  logic [1:0]          win_cls;
  logic [IW-1:0]       win_idx;

  assign elig = q_nempty_i & fifo_rdy_i;
  assign fire = !gnt_valid_o || (done_i && last_i);

  assign cls_req[CLS_A_HI] = elig &  prio_i & MASK_A;
  assign cls_req[CLS_A_LO] = elig & ~prio_i & MASK_A;
  assign cls_req[CLS_B_HI] = elig &  prio_i & MASK_B;
  assign cls_req[CLS_B_LO] = elig & ~prio_i & MASK_B;

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
    rr_pick #(.W(NUM_REQ), .IW(IW)) u_pick (
      .req_i (cls_req[c]),
      .ptr_i (ptr_q[c]),
      .any_o (cls_any[c]),
      .idx_o (cls_idx[c])
    );
  end

  assign any_a = cls_any[CLS_A_HI] | cls_any[CLS_A_LO];
  assign any_b = cls_any[CLS_B_HI] | cls_any[CLS_B_LO];

  grp_weight #(.RATIO_W(RATIO_W)) u_weight (
    .clk         (clk),
    .rst         (rst),
    .any_a_i     (any_a),
    .any_b_i     (any_b),
    .ratio_a_i   (ratio_a_i),
    .ratio_b_i   (ratio_b_i),
    .adv_i       (fire),
    .sel_valid_o (sel_valid),
    .sel_b_o     (sel_b)
  );

  always_comb begin
    if (sel_b) win_cls = cls_any[CLS_B_HI] ? 2'(CLS_B_HI) : 2'(CLS_B_LO);
    else       win_cls = cls_any[CLS_A_HI] ? 2'(CLS_A_HI) : 2'(CLS_A_LO);
    win_idx = cls_idx[win_cls];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_o       <= '0;
      gnt_valid_o <= 1'b0;
      gnt_grp_o   <= GRP_A;
      for (int c = 0; c < NUM_CLS; c++) ptr_q[c] <= '0;
    end else if (fire) begin
      gnt_valid_o <= sel_valid;
      gnt_o       <= sel_valid ? (NUM_REQ'(1) << win_idx) : '0;
      gnt_grp_o   <= sel_valid ? sel_b : GRP_A;
      if (sel_valid)
        ptr_q[win_cls] <= (int'(win_idx) == NUM_REQ - 1) ? '0 : win_idx + 1'b1;
    end
  end

  // R9
  onehot_grant_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt_o) && (gnt_valid_o == (|gnt_o)));

  // R9
  grp_match_chk: assert property (@(posedge clk) disable iff (rst)
    gnt_valid_o |-> (gnt_grp_o == (|(gnt_o & MASK_B))));

  // R6
  sg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    gnt_valid_o && !(done_i && last_i) |=> $stable(gnt_o) && gnt_valid_o);

  // R2
  idle_chk: assert property (@(posedge clk) disable iff (rst)
    fire && !(|elig) |=> !gnt_valid_o);

  // R3
  hi_first_chk: assert property (@(posedge clk) disable iff (rst)
    fire && sel_valid && (|(elig & prio_i & (sel_b ? MASK_B : MASK_A)))
    |=> (|(gnt_o & $past(prio_i))));
endmodule

// File: tb/rx_dma_arb_tb.sv
`timescale 1ns/1ps
module rx_dma_arb_tb;
  localparam int N  = 3;
  localparam int RW = 4;

  logic          clk = 1'b0;
  logic          rst;
  logic [N-1:0]  q_nempty, fifo_rdy, prio;
  logic [RW-1:0] ratio_a, ratio_b;
  logic          done, last;
  logic [N-1:0]  gnt;
  logic          gnt_valid, gnt_grp;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  rx_dma_arb #(.NUM_REQ(N), .NUM_A(1), .RATIO_W(RW)) u_dut (
    .clk(clk), .rst(rst), .q_nempty_i(q_nempty), .fifo_rdy_i(fifo_rdy),
    .prio_i(prio), .ratio_a_i(ratio_a), .ratio_b_i(ratio_b),
    .done_i(done), .last_i(last), .gnt_o(gnt), .gnt_valid_o(gnt_valid),
    .gnt_grp_o(gnt_grp)
  );

  // {q_nempty, fifo_rdy, prio, expected grant}; ratio_a=2, ratio_b=1
  localparam logic [11:0] VEC [12] = '{
    12'b000_111_000_000, // R2 nothing queued
    12'b111_011_000_001, // R2 req2 lacks data; R7 A first
    12'b111_111_000_001, // R7 A second
    12'b111_111_000_010, // R7 A budget used, B lo
    12'b111_111_000_001, // R7 B budget 1, back to A
    12'b110_111_000_100, // R8 A empty, B lo rr
    12'b110_111_000_010, // R4 lo pointer wrap
    12'b110_111_010_010, // R3 high wins over lo pointer
    12'b110_111_110_100, // R4 high rr
    12'b110_111_110_010, // R4 high rr wrap
    12'b110_111_001_100, // R5 only lo in B
    12'b011_111_000_001  // R7 B long run, A takes turn
  };

  function automatic string vtag(int i);
    case (i)
      0, 1:        return "R2";
      5:           return "R8";
      6, 8, 9:     return "R4";
      7:           return "R3";
      10:          return "R5";
      default:     return "R7";
    endcase
  endfunction

  task automatic check(string tag, logic [N-1:0] exp_g);
    logic exp_v, exp_grp;
    exp_v   = |exp_g;
    exp_grp = |(exp_g & 3'b110);
    n_chk++;
    if (gnt !== exp_g || gnt_valid !== exp_v || (exp_v && gnt_grp !== exp_grp)) begin
      n_bad++;
      $display("FAIL %s: gnt=%b valid=%b grp=%b expected gnt=%b valid=%b grp=%b",
               tag, gnt, gnt_valid, gnt_grp, exp_g, exp_v, exp_grp);
    end
  endtask

  // From idle: present eligibility, sample the grant, then release with no work left.
  task automatic packet(logic [N-1:0] ne, logic [N-1:0] ok, logic [N-1:0] pr,
                        logic [N-1:0] exp_g, string tag);
    q_nempty = ne; fifo_rdy = ok; prio = pr;
    @(posedge clk); @(negedge clk);
    check(tag, exp_g);
    done = 1'b1; last = 1'b1; q_nempty = '0;
    @(posedge clk); @(negedge clk);
    done = 1'b0; last = 1'b0;
  endtask

  initial begin
    #(5.0 * 100000);
    n_bad++;
    $display("FAIL watchdog: run did not complete, expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; q_nempty = '0; fifo_rdy = '0; prio = '0;
    ratio_a = 4'd2; ratio_b = 4'd1; done = 1'b0; last = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", 3'b000);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < 12; i++)
      packet(VEC[i][11:9], VEC[i][8:6], VEC[i][5:3], VEC[i][2:0], vtag(i));

    // R6 scatter-gather lock; state: last A, run 1
    q_nempty = 3'b111; fifo_rdy = 3'b111; prio = '0;
    @(posedge clk); @(negedge clk);
    check("R7", 3'b001);
    done = 1'b1; last = 1'b0; q_nempty = 3'b110; prio = 3'b110;
    @(posedge clk); @(negedge clk);
    check("R6", 3'b001);
    done = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R6", 3'b001);
    prio = '0;
    done = 1'b1; last = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R6", 3'b010);            // back-to-back grant, B lo pointer 0
    q_nempty = '0;
    @(posedge clk); @(negedge clk);
    done = 1'b0; last = 1'b0;
    check("R2", 3'b000);

    // R10 zero ratios behave as 1; state: last B, run 1, B lo pointer 2
    ratio_a = '0; ratio_b = '0;
    packet(3'b111, 3'b111, 3'b000, 3'b001, "R10");
    q_nempty = 3'b111;
    @(posedge clk); @(negedge clk);
    check("R10", 3'b100);

    // R1 reset while a grant is held
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R1", 3'b000);
    n_chk++;
    if (gnt_grp !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: grp=%b expected 0", gnt_grp);
    end
    rst = 1'b0; q_nempty = 3'b110; ratio_a = 4'd2; ratio_b = 4'd1;
    @(posedge clk); @(negedge clk);
    check("R1", 3'b010);            // pointers back at 0

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule